// File: doc/BRIEF.md
# Program Fetch Bus Sequencer with Two Port Pairs

This block produces the external instruction-fetch bus cycles for an 8-bit controller core. Everything runs from the oscillator clock. Each machine cycle is twelve oscillator periods long. It is split into six states of two periods each and holds two fetch slots. Each slot drives an address-latch pulse, then drives a read strobe on one of two port pairs. When the strobe rises, the slot captures the opcode and hands it to the core with a one-cycle valid pulse.

Each fetch can go to one of two pairs: a primary pair and an alternate pair. A strap input and an external-access input pick the pair. With the strap low, everything goes to the primary pair. With the strap high and external access low, everything goes to the alternate pair. With both high, the choice depends on the address: addresses below 2000H use the alternate pair, and addresses at 2000H and above use the primary pair. A strap-low, access-high setting is illegal. The block flags it and does not fetch.

A request for an external data-memory cycle, sampled at the start of a machine cycle, suppresses part of that cycle. The second latch pulse is dropped. Both primary strobes are dropped. Only the second alternate strobe is dropped. Reset, idle and power-down each park the pins at defined levels.

Top module: `fetch_bus_seq`

## Requirements
- R1: While `rst_n` is low, `ale`, `prim_rd_n` and `alt_rd_n` are all high and `op_valid` is low.
- R2: After reset is released, the machine cycle repeats every 12 clocks, with ticks numbered 0 to 11. Ticks 0 to 5 form slot 0 and ticks 6 to 11 form slot 1. With no data request, `ale` is high on ticks 0, 1, 6 and 7, and low on all other ticks.
- R3: In a fetching slot, the chosen pair's strobe is low on the four ticks after the latch pulse (2–5 or 8–11). The low-port input is sampled at the end of the last of these ticks. `op_valid` is then high for exactly one clock, with `op_addr` and `op_data` set to the slot's address and captured byte.
- R4: With `strap_sel`=0 and `ext_acc`=0, every fetch uses the primary pair. The high address byte is on `prim_hi`, and the low byte is on `prim_lo_out` during the latch pulse. `alt_rd_n` stays high.
- R5: With `strap_sel`=1 and `ext_acc`=0, every fetch uses the alternate pair. The high byte is on `alt_hi`, and the low byte is on `alt_lo_out` during the latch pulse. `prim_rd_n` stays high.
- R6: With `strap_sel`=1 and `ext_acc`=1, an address below 2000H is fetched on the alternate pair and an address of 2000H or above on the primary pair.
- R7: With `strap_sel`=0 and `ext_acc`=1, `cfg_err` is high, neither strobe goes low and no `op_valid` pulse occurs.
- R8: When `xdata_req` is high at the start of a machine cycle, that cycle has only the first `ale` pulse. Both primary strobe activations are skipped. On the alternate pair only the slot-1 activation is skipped.
- R9: When `idle_req` is high at a machine-cycle boundary, fetching stops with `ale`, `prim_rd_n` and `alt_rd_n` held high. When `idle_req` is low at a boundary, fetching resumes at tick 0.
- R10: When `pdown_req` is high at a machine-cycle boundary, `ale` and `prim_rd_n` go low and `alt_rd_n` stays high. Only reset ends this state.
- R11: While `strap_sel` is 0, the alternate pair drives all ones: `alt_hi`=FFH, `alt_lo_out`=FFH, `alt_lo_oe`=1.
- R12: The low port of the chosen pair is enabled only during its slot's latch pulse, for two ticks per fetch. It floats while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel | input | 1 | Strap choosing whether the alternate pair is in use |
| ext_acc | input | 1 | External-access input, enables the address split |
| fetch_addr | input | 16 | Fetch address from the core, taken at each slot start |
| xdata_req | input | 1 | External data-memory cycle request, taken at cycle start |
| idle_req | input | 1 | Idle request |
| pdown_req | input | 1 | Power-down request |
| ale | output | 1 | Address latch enable |
| prim_rd_n | output | 1 | Primary pair read strobe, active low |
| alt_rd_n | output | 1 | Alternate pair read strobe, active low |
| prim_hi | output | 8 | Primary pair high address byte |
| prim_lo_out | output | 8 | Primary multiplexed port, output value |
| prim_lo_oe | output | 1 | Primary multiplexed port, output enable |
| prim_lo_in | input | 8 | Primary multiplexed port, input value |
| alt_hi | output | 8 | Alternate pair high address byte |
| alt_lo_out | output | 8 | Alternate multiplexed port, output value |
| alt_lo_oe | output | 1 | Alternate multiplexed port, output enable |
| alt_lo_in | input | 8 | Alternate multiplexed port, input value |
| op_valid | output | 1 | One-clock pulse when an opcode is captured |
| op_addr | output | 16 | Address of the captured opcode |
| op_data | output | 8 | Captured opcode byte |
| cfg_err | output | 1 | Illegal strap/access combination |

## Verification
The bench goes after the 2000H split boundary by placing 1FFFH and 2000H in the two slots of one cycle. A design with an off-by-one split would read one of them from the wrong pair, and the scoreboard would see a byte from the other pair's memory function. Data-cycle suppression is checked with both pairs. A design that treats the pairs the same way would either drop the first alternate strobe or keep a primary one, which shows up as a wrong count of low-strobe ticks. Other targets are the illegal strap setting, which must produce no strobes and no pulses, and the stickiness of power-down after its request drops. The bench also checks that the slot-1 result of the last cycle before idle is still delivered.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [1:0] {
    PM_RESET = 2'd0,
    PM_RUN   = 2'd1,
    PM_IDLE  = 2'd2,
    PM_DOWN  = 2'd3
  } pm_mode_t;

  // strap low with external access high has no legal pair
  function automatic logic sel_invalid(input logic strap, input logic ea);
    return !strap && ea;
  endfunction

  // alternate pair: strap high and either no split or address under the split
  function automatic logic sel_alt(input logic strap, input logic ea,
                                   input logic below_split);
    return strap && (!ea || below_split);
  endfunction

  // a data cycle removes every primary slot and the second alternate slot
  function automatic logic fetch_enabled(input logic bad, input logic alt,
                                         input logic data_cyc, input logic second);
    return !bad && !(data_cyc && (second || !alt));
  endfunction

endpackage

// File: rtl/fbs_timebase.sv
module fbs_timebase
  import fbs_pkg::*;
#(
  parameter int CYC_LEN  = 12,
  parameter int SLOT_LEN = 6,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             pdown_req,
  output pm_mode_t         mode,
  output logic [CNT_W-1:0] cnt,
  output logic             slot_load,
  output logic             cyc_start,
  output logic             second_half
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(SLOT_LEN);

  pm_mode_t         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q == LAST);
    mode_d = mode_q;
    case (mode_q)
      PM_RESET: mode_d = PM_RUN;
      PM_RUN: begin
        if (at_end) begin
          if (pdown_req)     mode_d = PM_DOWN;
          else if (idle_req) mode_d = PM_IDLE;
        end
      end
      PM_IDLE: begin
        if (pdown_req)      mode_d = PM_DOWN;
        else if (!idle_req) mode_d = PM_RUN;
      end
      default: mode_d = PM_DOWN;
    endcase
    if (mode_d == PM_RUN) cnt_d = at_end ? '0 : cnt_q + 1'b1;
    else                  cnt_d = LAST;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_RESET;
      cnt_q  <= LAST;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode        = mode_q;
  assign cnt         = cnt_q;
  assign cyc_start   = (mode_d == PM_RUN) && (cnt_d == '0);
  assign slot_load   = (mode_d == PM_RUN) && ((cnt_d == '0) || (cnt_d == MID));
  assign second_half = (cnt_q >= MID);

endmodule

// File: rtl/fbs_route.sv
module fbs_route
  import fbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] SPLIT_ADDR = 'h2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     slot_load,
  input  logic                     cyc_start,
  input  logic                     strap_sel,
  input  logic                     ext_acc,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     xdata_req,
  output logic [ADDR_W-1:0]        slot_addr,
  output logic                     slot_alt,
  output logic                     slot_bad,
  output logic                     data_cyc,
  output logic [ADDR_W-DATA_W-1:0] prim_hi_q,
  output logic [ADDR_W-DATA_W-1:0] alt_hi_q
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic below, nxt_alt, nxt_bad;

  assign below   = (fetch_addr < SPLIT_ADDR);
  assign nxt_alt = sel_alt(strap_sel, ext_acc, below);
  assign nxt_bad = sel_invalid(strap_sel, ext_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_addr <= '0;
      slot_alt  <= 1'b0;
      slot_bad  <= 1'b1;
      data_cyc  <= 1'b0;
      prim_hi_q <= '1;
      alt_hi_q  <= '1;
    end else begin
      if (slot_load) begin
        slot_addr <= fetch_addr;
        slot_alt  <= nxt_alt;
        slot_bad  <= nxt_bad;
        if (!nxt_bad) begin
          if (nxt_alt) alt_hi_q  <= fetch_addr[ADDR_W-1 -: HI_W];
          else         prim_hi_q <= fetch_addr[ADDR_W-1 -: HI_W];
        end
      end
      if (cyc_start) data_cyc <= xdata_req;
    end
  end

endmodule

// File: rtl/fbs_pins.sv
module fbs_pins
  import fbs_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 8,
  parameter int SLOT_LEN        = 6,
  parameter int TICKS_PER_STATE = 2,
  parameter int CNT_W           = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pm_mode_t                 mode,
  input  logic [CNT_W-1:0]         cnt,
  input  logic                     second_half,
  input  logic                     strap_sel,
  input  logic [ADDR_W-1:0]        slot_addr,
  input  logic                     slot_alt,
  input  logic                     slot_bad,
  input  logic                     data_cyc,
  input  logic [ADDR_W-DATA_W-1:0] prim_hi_q,
  input  logic [ADDR_W-DATA_W-1:0] alt_hi_q,
  input  logic [DATA_W-1:0]        prim_lo_in,
  input  logic [DATA_W-1:0]        alt_lo_in,
  output logic                     ale,
  output logic                     prim_rd_n,
  output logic                     alt_rd_n,
  output logic [ADDR_W-DATA_W-1:0] prim_hi,
  output logic [DATA_W-1:0]        prim_lo_out,
  output logic                     prim_lo_oe,
  output logic [ADDR_W-DATA_W-1:0] alt_hi,
  output logic [DATA_W-1:0]        alt_lo_out,
  output logic                     alt_lo_oe,
  output logic                     op_valid,
  output logic [ADDR_W-1:0]        op_addr,
  output logic [DATA_W-1:0]        op_data
);

  localparam logic [CNT_W-1:0] SL    = CNT_W'(SLOT_LEN);
  localparam logic [CNT_W-1:0] TPS   = CNT_W'(TICKS_PER_STATE);
  localparam logic [CNT_W-1:0] SLAST = CNT_W'(SLOT_LEN - 1);

  logic             run, pd, hold_hi;
  logic [CNT_W-1:0] in_slot;
  logic             ale_win, fon, ale_run, p_take, a_take, cap;

  assign run     = (mode == PM_RUN);
  assign pd      = (mode == PM_DOWN);
  assign hold_hi = !run && !pd;
  assign in_slot = second_half ? (cnt - SL) : cnt;
  assign ale_win = (in_slot < TPS);
  assign fon     = fetch_enabled(slot_bad, slot_alt, data_cyc, second_half);
  assign ale_run = ale_win && !(data_cyc && second_half);
  assign p_take  = run && fon && !slot_alt;
  assign a_take  = run && fon && slot_alt;
  assign cap     = run && fon && (in_slot == SLAST);

  assign ale       = hold_hi ? 1'b1 : (pd ? 1'b0 : ale_run);
  assign prim_rd_n = hold_hi ? 1'b1 : (pd ? 1'b0 : !(p_take && !ale_win));
  assign alt_rd_n  = !(a_take && !ale_win);

  assign prim_hi     = prim_hi_q;
  assign prim_lo_out = slot_addr[DATA_W-1:0];
  assign prim_lo_oe  = p_take && ale_win;

  always_comb begin
    if (!strap_sel) begin
      alt_hi     = '1;
      alt_lo_out = '1;
      alt_lo_oe  = 1'b1;
    end else begin
      alt_hi     = alt_hi_q;
      alt_lo_out = slot_addr[DATA_W-1:0];
      alt_lo_oe  = a_take && ale_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_addr  <= '0;
      op_data  <= '0;
    end else begin
      op_valid <= cap;
      if (cap) begin
        op_addr <= slot_addr;
        op_data <= slot_alt ? alt_lo_in : prim_lo_in;
      end
    end
  end

endmodule

// File: rtl/fetch_bus_seq.sv
module fetch_bus_seq
  import fbs_pkg::*;
#(
  parameter int ADDR_W          = 16,
  parameter int DATA_W          = 8,
  parameter int NUM_STATES      = 6,
  parameter int TICKS_PER_STATE = 2,
  parameter logic [ADDR_W-1:0] SPLIT_ADDR = 'h2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     strap_sel,
  input  logic                     ext_acc,
  input  logic [ADDR_W-1:0]        fetch_addr,
  input  logic                     xdata_req,
  input  logic                     idle_req,
  input  logic                     pdown_req,
  output logic                     ale,
  output logic                     prim_rd_n,
  output logic                     alt_rd_n,
  output logic [ADDR_W-DATA_W-1:0] prim_hi,
  output logic [DATA_W-1:0]        prim_lo_out,
  output logic                     prim_lo_oe,
  input  logic [DATA_W-1:0]        prim_lo_in,
  output logic [ADDR_W-DATA_W-1:0] alt_hi,
  output logic [DATA_W-1:0]        alt_lo_out,
  output logic                     alt_lo_oe,
  input  logic [DATA_W-1:0]        alt_lo_in,
  output logic                     op_valid,
  output logic [ADDR_W-1:0]        op_addr,
  output logic [DATA_W-1:0]        op_data,
  output logic                     cfg_err
);

  localparam int CYC_LEN  = NUM_STATES * TICKS_PER_STATE;
  localparam int SLOT_LEN = CYC_LEN / 2;
  localparam int CNT_W    = $clog2(CYC_LEN);
  localparam int HI_W     = ADDR_W - DATA_W;

  pm_mode_t         mode;
  logic [CNT_W-1:0] cnt;
  logic             slot_load, cyc_start, second_half;
  logic [ADDR_W-1:0] slot_addr;
  logic             slot_alt, slot_bad, data_cyc;
  logic [HI_W-1:0]  prim_hi_q, alt_hi_q;

  // named events for the checker
  logic run_w, pd_mode_w, slot_bad_w;
  assign run_w      = (mode == PM_RUN);
  assign pd_mode_w  = (mode == PM_DOWN);
  assign slot_bad_w = slot_bad;

  assign cfg_err = sel_invalid(strap_sel, ext_acc);

  fbs_timebase #(.CYC_LEN(CYC_LEN), .SLOT_LEN(SLOT_LEN), .CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .pdown_req(pdown_req),
    .mode(mode), .cnt(cnt), .slot_load(slot_load), .cyc_start(cyc_start),
    .second_half(second_half)
  );

  fbs_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPLIT_ADDR(SPLIT_ADDR)) u_route (
    .clk(clk), .rst_n(rst_n), .slot_load(slot_load), .cyc_start(cyc_start),
    .strap_sel(strap_sel), .ext_acc(ext_acc), .fetch_addr(fetch_addr),
    .xdata_req(xdata_req), .slot_addr(slot_addr), .slot_alt(slot_alt),
    .slot_bad(slot_bad), .data_cyc(data_cyc), .prim_hi_q(prim_hi_q),
    .alt_hi_q(alt_hi_q)
  );

  fbs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN),
             .TICKS_PER_STATE(TICKS_PER_STATE), .CNT_W(CNT_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cnt(cnt), .second_half(second_half),
    .strap_sel(strap_sel), .slot_addr(slot_addr), .slot_alt(slot_alt),
    .slot_bad(slot_bad), .data_cyc(data_cyc), .prim_hi_q(prim_hi_q),
    .alt_hi_q(alt_hi_q), .prim_lo_in(prim_lo_in), .alt_lo_in(alt_lo_in),
    .ale(ale), .prim_rd_n(prim_rd_n), .alt_rd_n(alt_rd_n), .prim_hi(prim_hi),
    .prim_lo_out(prim_lo_out), .prim_lo_oe(prim_lo_oe), .alt_hi(alt_hi),
    .alt_lo_out(alt_lo_out), .alt_lo_oe(alt_lo_oe), .op_valid(op_valid),
    .op_addr(op_addr), .op_data(op_data)
  );

endmodule

// File: rtl/fbs_checker.sv
module fbs_checker (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic prim_rd_n,
  input logic alt_rd_n,
  input logic prim_lo_oe,
  input logic op_valid,
  input logic run_w,
  input logic pd_mode_w,
  input logic slot_bad_w
);

  // R1
  reset_pins_chk: assert property (@(posedge clk)
    !rst_n |-> (ale && prim_rd_n && alt_rd_n && !op_valid));

  // R3
  op_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!prim_rd_n && !alt_rd_n));

  // R2
  ale_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && ale) |-> (prim_rd_n && alt_rd_n));

  // R7
  bad_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && slot_bad_w) |-> (prim_rd_n && alt_rd_n && !prim_lo_oe));

  // R10
  pdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_mode_w |=> pd_mode_w);

  // R10
  pdown_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_mode_w |-> (!ale && !prim_rd_n && alt_rd_n));

endmodule

bind fetch_bus_seq fbs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .prim_rd_n(prim_rd_n),
  .alt_rd_n(alt_rd_n), .prim_lo_oe(prim_lo_oe), .op_valid(op_valid),
  .run_w(run_w), .pd_mode_w(pd_mode_w), .slot_bad_w(slot_bad_w)
);

// File: tb/fetch_bus_seq_test.sv
`timescale 1ns/1ps
module fetch_bus_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_sel = 1'b0, ext_acc = 1'b0, xdata_req = 1'b0;
  logic        idle_req = 1'b0, pdown_req = 1'b0;
  logic [15:0] fetch_addr = 16'h0;
  logic        ale, prim_rd_n, alt_rd_n, prim_lo_oe, alt_lo_oe, op_valid, cfg_err;
  logic [7:0]  prim_hi, prim_lo_out, prim_lo_in, alt_hi, alt_lo_out, alt_lo_in, op_data;
  logic [15:0] op_addr;

  int vectors = 0;
  int fails   = 0;
  logic [23:0] expq[$];
  logic [15:0] lat_p = 16'h0, lat_a = 16'h0;

  always #4 clk = ~clk;

  fetch_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .strap_sel(strap_sel), .ext_acc(ext_acc),
    .fetch_addr(fetch_addr), .xdata_req(xdata_req), .idle_req(idle_req),
    .pdown_req(pdown_req), .ale(ale), .prim_rd_n(prim_rd_n), .alt_rd_n(alt_rd_n),
    .prim_hi(prim_hi), .prim_lo_out(prim_lo_out), .prim_lo_oe(prim_lo_oe),
    .prim_lo_in(prim_lo_in), .alt_hi(alt_hi), .alt_lo_out(alt_lo_out),
    .alt_lo_oe(alt_lo_oe), .alt_lo_in(alt_lo_in), .op_valid(op_valid),
    .op_addr(op_addr), .op_data(op_data), .cfg_err(cfg_err)
  );

  function automatic logic [7:0] mem_p(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  function automatic logic [7:0] mem_a(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h91;
  endfunction

  // external memories: latch address during ALE, answer while strobe low
  always @(negedge clk) begin
    if (ale && prim_lo_oe) lat_p <= {prim_hi, prim_lo_out};
    if (ale && alt_lo_oe)  lat_a <= {alt_hi, alt_lo_out};
  end
  assign prim_lo_in = !prim_rd_n ? mem_p(lat_p) : 8'hEE;
  assign alt_lo_in  = !alt_rd_n  ? mem_a(lat_a) : 8'hEE;

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: pop expected fetches as the design reports them (R3)
  always @(negedge clk) begin
    if (rst_n && op_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3 unexpected op_valid", int'(op_addr), 0);
      end else begin
        logic [23:0] it;
        it = expq.pop_front();
        check({op_addr, op_data} == it, "R3 fetched item", int'({op_addr, op_data}), int'(it));
      end
    end
  end

  task automatic plan_slot(input bit s, input bit e, input bit xd, input bit second,
                           input logic [15:0] a, inout int pl, inout int al,
                           inout int po, inout int ao);
    bit use_alt, on;
    use_alt = s && (!e || (a < 16'h2000));
    on = !(!s && e) && !(xd && (second || !use_alt));
    if (on) begin
      if (use_alt) begin
        al += 4; ao += 2;
        expq.push_back({a, mem_a(a)});
      end else begin
        pl += 4; po += 2;
        expq.push_back({a, mem_p(a)});
      end
    end
  endtask

  // driver: called at a negedge just before a machine-cycle boundary
  task automatic run_cycle(input bit s, input bit e, input bit xd,
                           input logic [15:0] a0, input logic [15:0] a1);
    int ale_n = 0, pl_n = 0, al_n = 0, po_n = 0, ao_n = 0;
    int pl_e = 0, al_e = 0, po_e = 0, ao_e = 0;
    string tag;
    strap_sel = s; ext_acc = e; xdata_req = xd; fetch_addr = a0;
    plan_slot(s, e, xd, 1'b0, a0, pl_e, al_e, po_e, ao_e);
    plan_slot(s, e, xd, 1'b1, a1, pl_e, al_e, po_e, ao_e);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (ale) ale_n++;
      if (!prim_rd_n) pl_n++;
      if (!alt_rd_n) al_n++;
      if (prim_lo_oe) po_n++;
      if (alt_lo_oe) ao_n++;
      if (i == 5) fetch_addr = a1;
    end
    if (xd) tag = "R8";
    else if (!s && e) tag = "R7";
    else if (s && e) tag = "R6";
    else if (s) tag = "R5";
    else tag = "R4";
    check(ale_n == (xd ? 2 : 4), xd ? "R8 ale ticks" : "R2 ale ticks", ale_n, xd ? 2 : 4);
    check(pl_n == pl_e, {tag, " primary strobe ticks"}, pl_n, pl_e);
    check(al_n == al_e, {tag, " alternate strobe ticks"}, al_n, al_e);
    check(po_n == po_e, "R12 primary drive ticks", po_n, po_e);
    if (s) check(ao_n == ao_e, "R12 alternate drive ticks", ao_n, ao_e);
    else check(ao_n == 12 && alt_hi == 8'hFF && alt_lo_out == 8'hFF,
               "R11 alternate pair all ones", ao_n, 12);
    check(cfg_err == (!s && e), "R7 cfg_err", cfg_err, (!s && e));
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R1 reset pin state
    check(ale && prim_rd_n && alt_rd_n && !op_valid, "R1 reset pins",
          {ale, prim_rd_n, alt_rd_n, op_valid}, 4'b1110);
    rst_n = 1'b1;
    run_cycle(0, 0, 0, 16'h1234, 16'h1235);   // R4
    run_cycle(0, 0, 1, 16'h0100, 16'h0101);   // R8 primary
    run_cycle(1, 0, 0, 16'h3456, 16'h3457);   // R5
    run_cycle(1, 0, 1, 16'h4000, 16'h4001);   // R8 alternate
    run_cycle(1, 1, 0, 16'h1FFF, 16'h2000);   // R6 boundary
    run_cycle(1, 1, 0, 16'hA000, 16'h0000);   // R6
    run_cycle(0, 1, 0, 16'h1111, 16'h2222);   // R7
    run_cycle(1, 1, 1, 16'h2500, 16'h0005);   // R8 with split
    run_cycle(0, 0, 0, 16'hBEEF, 16'hBEF0);
    // R9 idle
    idle_req = 1'b1;
    ok = 1'b1;
    repeat (20) begin
      @(posedge clk); @(negedge clk);
      if (!(ale && prim_rd_n && alt_rd_n)) ok = 1'b0;
    end
    check(ok, "R9 idle pins", {ale, prim_rd_n, alt_rd_n}, 3'b111);
    check(alt_hi == 8'hFF && alt_lo_out == 8'hFF && alt_lo_oe, "R11 idle alternate pair",
          {alt_hi, alt_lo_out}, 16'hFFFF);
    idle_req = 1'b0;
    run_cycle(0, 0, 0, 16'h0042, 16'h0043);   // R9 resume
    // R10 power-down
    pdown_req = 1'b1;
    ok = 1'b1;
    repeat (20) begin
      @(posedge clk); @(negedge clk);
      if (!(!ale && !prim_rd_n && alt_rd_n)) ok = 1'b0;
    end
    check(ok, "R10 power-down pins", {ale, prim_rd_n, alt_rd_n}, 3'b001);
    pdown_req = 1'b0;
    ok = 1'b1;
    repeat (30) begin
      @(posedge clk); @(negedge clk);
      if (!(!ale && !prim_rd_n && alt_rd_n)) ok = 1'b0;
    end
    check(ok, "R10 power-down held after request drops", {ale, prim_rd_n, alt_rd_n}, 3'b001);
    rst_n = 1'b0;
    @(negedge clk);
    check(ale && prim_rd_n && alt_rd_n && !op_valid, "R1 reset from power-down",
          {ale, prim_rd_n, alt_rd_n, op_valid}, 4'b1110);
    rst_n = 1'b1;
    run_cycle(1, 0, 0, 16'h7777, 16'h7778);
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R3 all fetches delivered", expq.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule